// File: doc/BRIEF.md
# Dual-Clock Programmable Line Delay Channel

This block is one channel of line or field storage that acts as a programmable delay line. The write side and the read side each have their own clock, an active-low enable and an active-low synchronous reset. Each side keeps a free-running address counter. When a counter reaches the last word it returns to zero, and no flag reports this. The block has no full or empty indication.

The delay between a written word and the time it reappears is set only by the user's timing. One way is to reset the two counters some number of cycles apart. Another is to reset them together and then hold read enable inactive for as long as the delay should last. When both counters run without interruption, the delay equals the depth. A word can only be read back correctly once at least 16 write-clock edges have passed since it was stored. The high-impedance output of a real pin is modelled as a data bus with a separate output-enable flag, and the bus is driven to zero while the flag is low.

Top module: `delay_line_channel`

## Requirements
- R1: When `wr_en_n` is low at a rising `wclk` edge, `wr_data` is stored at the current write address and the write address advances by one.
- R2: When `wr_en_n` is high at a rising `wclk` edge, no word is stored and the write address holds. Words stored earlier read back unchanged.
- R3: When `wr_rst_n` is low at a rising `wclk` edge, the write address becomes 0, so the next enabled write goes to word 0.
- R4: When `rd_en_n` is low at a rising `rclk` edge, the word at the read address appears on `rd_data`, `rd_oe` is 1 after that edge, and the read address advances. When `rd_rst_n` is low at an edge, the next read returns word 0.
- R5: When `rd_en_n` is high at a rising `rclk` edge, `rd_oe` is 0 and `rd_data` is 0 after that edge, and the read address holds. The next enabled read continues at the following word. This also holds after reset.
- R6: Both address counters wrap from DEPTH-1 to 0. Writing DEPTH+k words after a write reset replaces words 0..k-1.
- R7: A reset and an enable at the same edge act together. The write stores at the old address, and the read returns the word at the old address. The counter then starts again from 0.
- R8: If both sides are reset together and read enable is then held high for n read cycles while writing continues, the first enabled read returns the first word written after the reset.
- R9: With both clocks running freely and unrelated, every read of a word that was stored at least 16 write edges earlier returns the most recently stored value of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Active-low synchronous write address reset |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DATA_W | Write data |
| rclk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Active-low synchronous read address reset |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | DATA_W | Read data, zero while the output is disabled |
| rd_oe | output | 1 | Output enable, high after an enabled read edge |

## Verification
The hardest situation to reach from the ports is the one in R9. Here the writer laps the reader on clocks of unrelated periods, so some words are read too close to their write and their value is undefined. The bench keeps a reference copy of every word, together with the write-edge index at which it was stored. A read is compared only when that word has been stored for at least 16 write edges, and the run is long enough that the faster writer overtakes the reader several times. The combined reset and enable edges of R7 are placed at known addresses, and the result is then read back so that the old-address effect can be seen at the output.

// File: rtl/dlc_pkg.sv
// Shared helpers for the line delay channel.
// Assumes addresses are held as unsigned integers below the depth.
package dlc_pkg;

    // Next position on a ring of the given depth.
    function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/dlc_wr_side.sv
// Write-side address counter for the line delay channel.
// Counts enabled write edges, wraps silently at DEPTH-1 and returns to zero
// on a synchronous active-low reset. Assumes DEPTH >= 2.
module dlc_wr_side #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          wclk,
    input  logic          wr_rst_n,
    input  logic          wr_en_n,
    output logic [AW-1:0] waddr,
    output logic          wr_fire
);
    import dlc_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic armed;

    // A store takes place on every enabled edge, reset or not.
    always_comb wr_fire = !wr_en_n;

    // Write address: reset to zero, step on enable, otherwise hold.
    always_ff @(posedge wclk) begin
        if (!wr_rst_n)
            waddr <= '0;
        else if (!wr_en_n)
            waddr <= AW'(ring_next(int'(waddr), DEPTH));
    end

    // Marks that a reset has been seen, so that checks start from a known state.
    always_ff @(posedge wclk) begin
        if (!wr_rst_n)
            armed <= 1'b1;
    end

    AST_WR_ZERO: assert property (@(posedge wclk) disable iff (!armed)
        !wr_rst_n |=> (waddr == '0)); // R3
    AST_WR_HOLD: assert property (@(posedge wclk) disable iff (!armed)
        (wr_rst_n && wr_en_n) |=> $stable(waddr)); // R2
    AST_WR_STEP: assert property (@(posedge wclk) disable iff (!armed)
        (wr_rst_n && !wr_en_n) |=>
        (waddr == (($past(waddr) == LAST) ? '0 : $past(waddr) + 1'b1))); // R6

endmodule

// File: rtl/dlc_rd_side.sv
// Read-side address counter and output-enable flag for the line delay channel.
// The flag follows the enable of the last read edge, standing in for a
// three-state pad. Assumes DEPTH >= 2.
module dlc_rd_side #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          rclk,
    input  logic          rd_rst_n,
    input  logic          rd_en_n,
    output logic [AW-1:0] raddr,
    output logic          rd_fire,
    output logic          rd_oe
);
    import dlc_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic armed;

    // A word is fetched on every enabled edge, reset or not.
    always_comb rd_fire = !rd_en_n;

    // Read address: reset to zero, step on enable, otherwise hold.
    always_ff @(posedge rclk) begin
        if (!rd_rst_n)
            raddr <= '0;
        else if (!rd_en_n)
            raddr <= AW'(ring_next(int'(raddr), DEPTH));
    end

    // Output enable reflects whether the last edge was a read.
    always_ff @(posedge rclk) begin
        rd_oe <= !rd_en_n;
    end

    // Marks that a reset has been seen, so that checks start from a known state.
    always_ff @(posedge rclk) begin
        if (!rd_rst_n)
            armed <= 1'b1;
    end

    AST_RD_ZERO: assert property (@(posedge rclk) disable iff (!armed)
        !rd_rst_n |=> (raddr == '0)); // R4
    AST_RD_HOLD: assert property (@(posedge rclk) disable iff (!armed)
        (rd_rst_n && rd_en_n) |=> $stable(raddr)); // R5
    AST_RD_STEP: assert property (@(posedge rclk) disable iff (!armed)
        (rd_rst_n && !rd_en_n) |=>
        (raddr == (($past(raddr) == LAST) ? '0 : $past(raddr) + 1'b1))); // R6

endmodule

// File: rtl/dlc_store.sv
// Simple dual-port storage: one write port on wclk and one registered read
// port on rclk. Assumes the user keeps 16 write edges between the store and
// the read of a word. A closer read is undefined by contract.
module dlc_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    parameter int AW     = 10
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rq
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write port: commit the input word at the write address.
    always_ff @(posedge wclk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Read port: fetch the word at the read address on an enabled edge.
    always_ff @(posedge rclk) begin
        if (re)
            rq <= mem[raddr];
    end

endmodule

// File: rtl/delay_line_channel.sv
// Top of the dual-clock programmable line delay channel.
// Joins the write counter, the read counter and the storage. The output
// bus is forced to zero while the output enable is low. Assumes DEPTH >= 16,
// so that a valid delay exists.
module delay_line_channel #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024
) (
    input  logic              wclk,
    input  logic              wr_rst_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rclk,
    input  logic              rd_rst_n,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic              wr_fire;
    logic              rd_fire;
    logic [DATA_W-1:0] rq;

    dlc_wr_side #(.DEPTH(DEPTH), .AW(AW)) wr_i (
        .wclk    (wclk),
        .wr_rst_n(wr_rst_n),
        .wr_en_n (wr_en_n),
        .waddr   (waddr),
        .wr_fire (wr_fire)
    );

    dlc_rd_side #(.DEPTH(DEPTH), .AW(AW)) rd_i (
        .rclk    (rclk),
        .rd_rst_n(rd_rst_n),
        .rd_en_n (rd_en_n),
        .raddr   (raddr),
        .rd_fire (rd_fire),
        .rd_oe   (rd_oe)
    );

    dlc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) st_i (
        .wclk (wclk),
        .we   (wr_fire),
        .waddr(waddr),
        .wdata(wr_data),
        .rclk (rclk),
        .re   (rd_fire),
        .raddr(raddr),
        .rq   (rq)
    );

    // Quiet bus while disabled, in place of high impedance.
    always_comb rd_data = rd_oe ? rq : '0;

endmodule

// File: tb/delay_line_channel_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the line delay channel, with a reference scoreboard.
module delay_line_channel_tb_top;
    localparam int W     = 8;
    localparam int DEPTH = 64;

    logic         wclk = 1'b0;
    logic         rclk = 1'b0;
    logic         wr_rst_n = 1'b1;
    logic         wr_en_n  = 1'b1;
    logic [W-1:0] wr_data  = '0;
    logic         rd_rst_n = 1'b1;
    logic         rd_en_n  = 1'b1;
    logic [W-1:0] rd_data;
    logic         rd_oe;

    int checks   = 0;
    int failures = 0;

    always #4    wclk = ~wclk;   // 125 MHz write clock
    always #4.85 rclk = ~rclk;   // unrelated read clock

    delay_line_channel #(.DATA_W(W), .DEPTH(DEPTH)) dut_i (
        .wclk(wclk), .wr_rst_n(wr_rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rclk(rclk), .rd_rst_n(rd_rst_n), .rd_en_n(rd_en_n),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model built from the requirements
    logic [W-1:0] ref_mem [DEPTH];
    int           ref_stamp [DEPTH];
    bit           ref_wr [DEPTH];
    int           ref_waddr = 0;
    int           ref_raddr = 0;
    int           wcyc = 0;
    logic [W-1:0] exp_q;
    bit           exp_ok = 0;
    bit           exp_on = 0;
    bit           sb_en = 0;
    string        cur_tag = "R4";

    always @(posedge wclk) begin
        wcyc <= wcyc + 1;
        if (!wr_en_n) begin
            ref_mem[ref_waddr]   <= wr_data;
            ref_stamp[ref_waddr] <= wcyc;
            ref_wr[ref_waddr]    <= 1'b1;
        end
        if (!wr_rst_n)     ref_waddr <= 0;
        else if (!wr_en_n) ref_waddr <= (ref_waddr + 1) % DEPTH;
    end

    always @(posedge rclk) begin
        if (!rd_en_n) begin
            exp_q  <= ref_mem[ref_raddr];
            exp_ok <= ref_wr[ref_raddr] && ((wcyc - ref_stamp[ref_raddr]) >= 16);
        end
        exp_on <= !rd_en_n;
        if (!rd_rst_n)     ref_raddr <= 0;
        else if (!rd_en_n) ref_raddr <= (ref_raddr + 1) % DEPTH;
    end

    always @(negedge rclk) begin
        if (sb_en) begin
            if (exp_on && exp_ok)
                chk(rd_oe === 1'b1 && rd_data === exp_q, cur_tag, int'(rd_data), int'(exp_q));
            else if (!exp_on)
                chk(rd_oe === 1'b0, "R5", int'(rd_oe), 0);
        end
    end

    task automatic wr_cycle(bit rst_n, bit en_n, logic [W-1:0] d);
        @(negedge wclk);
        wr_rst_n = rst_n; wr_en_n = en_n; wr_data = d;
    endtask

    task automatic wr_idle();
        wr_cycle(1'b1, 1'b1, '0);
    endtask

    task automatic rd_cycle(bit rst_n, bit en_n, output logic [W-1:0] q, output logic oe);
        @(negedge rclk);
        rd_rst_n = rst_n; rd_en_n = en_n;
        @(posedge rclk);
        #1;
        q = rd_data; oe = rd_oe;
    endtask

    task automatic t_reset();
        logic [W-1:0] q; logic oe;
        for (int i = 0; i < 3; i++) wr_cycle(1'b0, 1'b1, '0);
        wr_idle();
        for (int i = 0; i < 3; i++) rd_cycle(1'b0, 1'b1, q, oe);
        chk(oe === 1'b0, "R5", int'(oe), 0);
        chk(q === '0, "R5", int'(q), 0);
        sb_en = 1;
    endtask

    task automatic t_sequential();
        logic [W-1:0] q; logic oe;
        cur_tag = "R1";
        wr_cycle(1'b0, 1'b1, '0);
        for (int i = 0; i < 40; i++) wr_cycle(1'b1, 1'b0, W'(8'hA0 + i));
        wr_idle();
        rd_cycle(1'b0, 1'b1, q, oe);
        for (int i = 0; i < 40; i++) begin
            rd_cycle(1'b1, 1'b0, q, oe);
            chk(oe === 1'b1 && q === W'(8'hA0 + i), (i == 0) ? "R4" : "R1",
                int'(q), int'(W'(8'hA0 + i)));
        end
    endtask

    task automatic t_gaps();
        logic [W-1:0] q; logic oe;
        cur_tag = "R2";
        wr_cycle(1'b0, 1'b1, '0);
        for (int i = 0; i < 30; i++) wr_cycle(1'b1, i[0], W'(8'h10 + i));
        wr_idle();
        rd_cycle(1'b0, 1'b1, q, oe);
        for (int k = 0; k < 15; k++) begin
            rd_cycle(1'b1, 1'b0, q, oe);
            chk(q === W'(8'h10 + 2 * k), (k == 0) ? "R3" : "R2", int'(q), int'(W'(8'h10 + 2 * k)));
        end
        rd_cycle(1'b1, 1'b0, q, oe);
        chk(q === W'(8'hA0 + 15), "R2", int'(q), int'(W'(8'hA0 + 15)));
    endtask

    task automatic t_stall();
        logic [W-1:0] q; logic oe;
        cur_tag = "R5";
        rd_cycle(1'b0, 1'b1, q, oe);
        for (int k = 0; k < 5; k++) rd_cycle(1'b1, 1'b0, q, oe);
        for (int k = 0; k < 4; k++) begin
            rd_cycle(1'b1, 1'b1, q, oe);
            chk(oe === 1'b0, "R5", int'(oe), 0);
            chk(q === '0, "R5", int'(q), 0);
        end
        rd_cycle(1'b1, 1'b0, q, oe);
        chk(oe === 1'b1 && q === W'(8'h1A), "R5", int'(q), 8'h1A);
    endtask

    task automatic t_reset_with_enable();
        logic [W-1:0] q; logic oe;
        cur_tag = "R7";
        wr_cycle(1'b0, 1'b1, '0);
        for (int i = 0; i < 10; i++) wr_cycle(1'b1, 1'b0, W'(8'h40 + i));
        wr_cycle(1'b0, 1'b0, W'(8'h5A));
        for (int i = 0; i < 3; i++) wr_cycle(1'b1, 1'b0, W'(8'h70 + i));
        wr_idle();
        rd_cycle(1'b0, 1'b1, q, oe);
        for (int k = 0; k < 11; k++) begin
            logic [W-1:0] e;
            e = (k < 3) ? W'(8'h70 + k) : (k < 10) ? W'(8'h40 + k) : W'(8'h5A);
            rd_cycle(1'b1, 1'b0, q, oe);
            chk(q === e, "R7", int'(q), int'(e));
        end
        rd_cycle(1'b0, 1'b0, q, oe);
        chk(oe === 1'b1 && q === W'(8'h26), "R7", int'(q), 8'h26);
        rd_cycle(1'b1, 1'b0, q, oe);
        chk(q === W'(8'h70), "R7", int'(q), 8'h70);
    endtask

    task automatic t_wrap();
        logic [W-1:0] q; logic oe;
        cur_tag = "R6";
        wr_cycle(1'b0, 1'b1, '0);
        for (int i = 0; i < DEPTH + 6; i++) wr_cycle(1'b1, 1'b0, W'(i * 3 + 1));
        wr_idle();
        rd_cycle(1'b0, 1'b1, q, oe);
        for (int k = 0; k < DEPTH + 2; k++) begin
            int a; int src; logic [W-1:0] e;
            a   = k % DEPTH;
            src = (a < 6) ? DEPTH + a : a;
            e   = W'(src * 3 + 1);
            rd_cycle(1'b1, 1'b0, q, oe);
            chk(q === e, "R6", int'(q), int'(e));
        end
    endtask

    task automatic t_stall_delay();
        cur_tag = "R8";
        fork
            begin
                wr_cycle(1'b0, 1'b1, '0);
                for (int i = 0; i < 400; i++) wr_cycle(1'b1, 1'b0, W'(i * 7 + 3));
                wr_idle();
            end
            begin
                logic [W-1:0] q; logic oe;
                rd_cycle(1'b0, 1'b1, q, oe);
                for (int k = 0; k < 20; k++) begin
                    rd_cycle(1'b1, 1'b1, q, oe);
                    chk(oe === 1'b0, "R8", int'(oe), 0);
                end
                rd_cycle(1'b1, 1'b0, q, oe);
                chk(q === W'(3), "R8", int'(q), 3);
                for (int k = 0; k < 300; k++) rd_cycle(1'b1, 1'b0, q, oe);
                rd_cycle(1'b1, 1'b1, q, oe);
            end
        join
    endtask

    task automatic t_free_run();
        int start;
        cur_tag = "R9";
        start = wcyc;
        fork
            begin
                wr_cycle(1'b0, 1'b1, '0);
                for (int i = 0; i < 250; i++) wr_cycle(1'b1, 1'b0, W'(i * 5 + 2));
                wr_idle();
            end
            begin
                logic [W-1:0] q; logic oe;
                wait (wcyc >= start + 20);
                rd_cycle(1'b0, 1'b1, q, oe);
                rd_cycle(1'b1, 1'b0, q, oe);
                chk(q === W'(2), "R9", int'(q), 2);
                for (int k = 0; k < 200; k++) rd_cycle(1'b1, 1'b0, q, oe);
                rd_cycle(1'b1, 1'b1, q, oe);
            end
        join
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        t_reset();
        t_sequential();
        t_gaps();
        t_stall();
        t_reset_with_enable();
        t_wrap();
        t_stall_delay();
        t_free_run();
        repeat (4) @(negedge rclk);
        finish_run();
    end

endmodule